// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit logical address into a physical page address. It walks three tables in memory: a root table, then a pointer table, then a page table. It handles one walk at a time. A request is accepted when `start_i` is high while the block is idle. The block reads the descriptors over a single-word memory port, which can take any number of cycles to acknowledge. It reports the physical page, the read, write and execute permissions, and a fault flag. When the request is a probe, it also reports a status word.

On the way down, the walk writes back the used and modified bits of the descriptors. It collects write protection from every level. It can follow one indirect hop at the page level. A run-time control selects pages of 4 KiB or 8 KiB. A debug request performs the same lookup but never writes to memory.

Top module: `ptw_walker`

## Requirements
- R1: The walk starts from `root_super_i` when `super_i` is high and from `root_user_i` otherwise. The first entry address is {root[31:9], vaddr[31:25], 2'b00}.
- R2: The walk reads the root entry, then the pointer entry at {root_desc[31:9], vaddr[24:18], 2'b00}, then the page entry. An upper-level descriptor is valid only when bit 1 is set. An invalid upper descriptor ends the walk with `fault_o`, and no further memory access follows.
- R3: If an upper-level descriptor has its used bit (bit 3) clear and the request is not debug, the walk writes that descriptor back to its own address with bit 3 set. This write happens before the next read.
- R4: A write-protect bit (bit 2) set at any level clears `perm_w_o`. A store to such a path faults. For an upper-level protection, the fault comes right after that level's write-back and no further read follows. In a probe, an upper-level protection also sets status bit 2.
- R5: With `big_page_i` low, the page entry address is {ptr_desc[31:8], vaddr[17:12], 2'b00} and the physical page is desc[31:12] followed by zeros. With `big_page_i` high, the page entry address is {ptr_desc[31:7], vaddr[17:13], 2'b00} and the physical page is desc[31:13] followed by zeros.
- R6: Page descriptor type bits [1:0] are decoded as follows:
  - 00: invalid, and the walk faults.
  - 10: indirect. The walk makes exactly one more read, at {desc[31:2], 2'b00}, and uses the word it reads as the final descriptor.
  - Any other value: resident.
- R7: The final descriptor is written back to the address it was read from, as follows:
  - A store to a page without bit 2 writes the descriptor with bit 3 and bit 4 (modified) set, if either of them is clear.
  - Any other non-debug access writes the descriptor with bit 3 set, if bit 3 is clear.
  - A debug request never writes.
- R8: A final descriptor with bit 7 (supervisor only) set faults when `super_i` is low.
- R9: In a probe, `status_o` holds the following fields, taken from the final descriptor as it was read:
  - bits 10:2 of the descriptor;
  - the physical page in bits 31:12;
  - the resident bit 0.

  Status bits set by upper-level protection are kept. Outside a probe, `status_o` is zero.
- R10: `start_i` is taken only when idle. `busy_o` is high during the walk. `done_o` is a single-cycle pulse, and all results hold until the next start. On a fault, all permission outputs are 0. Otherwise `perm_r_o` is 1, `perm_w_o` is the inverse of the collected protection, and `perm_x_o` equals `code_i`.
- R11: A memory request keeps its address, direction and write data stable until `mem_ack_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a walk (taken when idle) |
| vaddr_i | input | 32 | Logical address |
| super_i | input | 1 | Supervisor access |
| code_i | input | 1 | Instruction fetch; grants execute |
| store_i | input | 1 | Write access |
| probe_i | input | 1 | Probe request; fills status |
| debug_i | input | 1 | Lookup without write-back |
| big_page_i | input | 1 | 1 = 8 KiB pages, 0 = 4 KiB pages |
| root_super_i | input | 32 | Supervisor root table pointer |
| root_user_i | input | 32 | User root table pointer |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Result pulse |
| phys_o | output | 32 | Physical page address |
| perm_r_o | output | 1 | Read allowed |
| perm_w_o | output | 1 | Write allowed |
| perm_x_o | output | 1 | Execute allowed |
| fault_o | output | 1 | Translation fault |
| status_o | output | 32 | Probe status word |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 32 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data |
| mem_ack_i | input | 1 | Memory acknowledge |

## Verification
A walk takes a variable number of cycles:
- Each read or write-back takes the memory latency plus one cycle.
- Each descriptor then costs one cycle to check and one cycle to advance.
- The results appear in the single cycle in which `done_o` is high.

The bench does not wait for a fixed cycle count. Its monitor samples on every falling edge and compares each `done_o` pulse against the next queued expectation. At that same pulse it also compares the counts of memory reads and writes and the memory image. Latency is varied from test to test. A few cycles after the pulse, the bench samples the results again to confirm they are held.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_CHK, ST_WB, ST_ADV, ST_DONE} ptw_state_e;
  typedef enum logic [1:0] {LV_ROOT, LV_PTR, LV_PAGE, LV_IND} ptw_level_e;
  typedef enum logic [1:0] {PG_INVALID, PG_RESIDENT, PG_INDIRECT} pg_kind_e;

  localparam int DSC_UP_VALID = 1;
  localparam int DSC_WP       = 2;
  localparam int DSC_USED     = 3;
  localparam int DSC_MOD      = 4;
  localparam int DSC_SUPER    = 7;
  localparam int STAT_RES     = 0;
  localparam int STAT_LO      = 2;
  localparam int STAT_HI      = 10;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int AW          = 32,
  parameter int ROOT_IW     = 7,
  parameter int PTR_IW      = 7,
  parameter int SMALL_SHIFT = 12
) (
  input  logic [AW-1:0] root_ptr_i,
  input  logic [AW-1:0] root_va_i,
  input  logic [AW-1:0] vaddr_i,
  input  logic [AW-1:0] desc_i,
  input  ptw_level_e    lvl_i,
  input  logic          big_page_i,
  output logic [AW-1:0] root_entry_o,
  output logic [AW-1:0] next_entry_o,
  output logic [AW-1:0] ind_entry_o,
  output logic [AW-1:0] phys_o
);
  localparam int ROOT_LSB = AW - ROOT_IW;
  localparam int PTR_LSB  = ROOT_LSB - PTR_IW;

  logic [1:0][AW-1:0] pg_entry;
  logic [1:0][AW-1:0] pg_phys;
  logic [AW-1:0]      ptr_entry;

  assign root_entry_o = {root_ptr_i[AW-1:ROOT_IW+2], root_va_i[AW-1:ROOT_LSB], 2'b00};
  assign ptr_entry    = {desc_i[AW-1:PTR_IW+2], vaddr_i[ROOT_LSB-1:PTR_LSB], 2'b00};
  assign ind_entry_o  = {desc_i[AW-1:2], 2'b00};

  // index 0: small pages, index 1: double-size pages
  for (genvar g = 0; g < 2; g++) begin : g_pgsz
    localparam int SH = SMALL_SHIFT + g;
    localparam int IW = PTR_LSB - SH;
    assign pg_entry[g] = {desc_i[AW-1:IW+2], vaddr_i[PTR_LSB-1:SH], 2'b00};
    assign pg_phys[g]  = desc_i & ({AW{1'b1}} << SH);
  end

  assign next_entry_o = (lvl_i == LV_ROOT) ? ptr_entry : pg_entry[big_page_i];
  assign phys_o       = pg_phys[big_page_i];

  logic unused_bits;
  assign unused_bits = ^{root_ptr_i[ROOT_IW+1:0], root_va_i[ROOT_LSB-1:0],
                         vaddr_i[AW-1:ROOT_LSB], vaddr_i[SMALL_SHIFT-1:0]};
endmodule

// File: rtl/ptw_desc_eval.sv
module ptw_desc_eval
  import ptw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] desc_i,
  input  ptw_level_e    lvl_i,
  input  logic          store_i,
  input  logic          debug_i,
  output logic          up_valid_o,
  output pg_kind_e      pg_kind_o,
  output logic          wp_o,
  output logic          wb_need_o,
  output logic [AW-1:0] wb_data_o
);
  logic upper;
  logic used, modf;

  assign upper      = (lvl_i == LV_ROOT) || (lvl_i == LV_PTR);
  assign up_valid_o = desc_i[DSC_UP_VALID];
  assign wp_o       = desc_i[DSC_WP];
  assign used       = desc_i[DSC_USED];
  assign modf       = desc_i[DSC_MOD];

  always_comb begin
    unique case (desc_i[1:0])
      2'b00:   pg_kind_o = PG_INVALID;
      2'b10:   pg_kind_o = PG_INDIRECT;
      default: pg_kind_o = PG_RESIDENT;
    endcase
  end

  always_comb begin
    wb_need_o = 1'b0;
    wb_data_o = desc_i;
    if (!debug_i) begin
      if (upper) begin
        wb_need_o = !used;
        wb_data_o[DSC_USED] = 1'b1;
      end else if (store_i && !wp_o) begin
        wb_need_o = !(used && modf);
        wb_data_o[DSC_USED] = 1'b1;
        wb_data_o[DSC_MOD]  = 1'b1;
      end else begin
        wb_need_o = !used;
        wb_data_o[DSC_USED] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int AW          = 32,
  parameter int ROOT_IW     = 7,
  parameter int PTR_IW      = 7,
  parameter int SMALL_SHIFT = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] vaddr_i,
  input  logic          super_i,
  input  logic          code_i,
  input  logic          store_i,
  input  logic          probe_i,
  input  logic          debug_i,
  input  logic          big_page_i,
  input  logic [AW-1:0] root_super_i,
  input  logic [AW-1:0] root_user_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] phys_o,
  output logic          perm_r_o,
  output logic          perm_w_o,
  output logic          perm_x_o,
  output logic          fault_o,
  output logic [AW-1:0] status_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] mem_wdata_o,
  input  logic [AW-1:0] mem_rdata_i,
  input  logic          mem_ack_i
);
  localparam logic [AW-1:0] STAT_MASK = AW'((1 << (STAT_HI + 1)) - (1 << STAT_LO));

  ptw_state_e    state_q;
  ptw_level_e    lvl_q;
  logic [AW-1:0] va_q, ent_q, desc_q, wb_q, phys_q, stat_q;
  logic          sup_q, code_q, st_q, prb_q, dbg_q, big_q;
  logic          wp_q, fault_q;
  logic [2:0]    perm_q;

  logic [AW-1:0] root_sel, root_entry, next_entry, ind_entry, page_phys, wb_data;
  logic          up_valid, desc_wp, wb_need;
  pg_kind_e      pg_kind;
  logic          is_upper;

  assign root_sel = super_i ? root_super_i : root_user_i;
  assign is_upper = (lvl_q == LV_ROOT) || (lvl_q == LV_PTR);

  ptw_addr_gen #(
    .AW(AW), .ROOT_IW(ROOT_IW), .PTR_IW(PTR_IW), .SMALL_SHIFT(SMALL_SHIFT)
  ) u_addr (
    .root_ptr_i  (root_sel),
    .root_va_i   (vaddr_i),
    .vaddr_i     (va_q),
    .desc_i      (desc_q),
    .lvl_i       (lvl_q),
    .big_page_i  (big_q),
    .root_entry_o(root_entry),
    .next_entry_o(next_entry),
    .ind_entry_o (ind_entry),
    .phys_o      (page_phys)
  );

  ptw_desc_eval #(.AW(AW)) u_eval (
    .desc_i    (desc_q),
    .lvl_i     (lvl_q),
    .store_i   (st_q),
    .debug_i   (dbg_q),
    .up_valid_o(up_valid),
    .pg_kind_o (pg_kind),
    .wp_o      (desc_wp),
    .wb_need_o (wb_need),
    .wb_data_o (wb_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lvl_q   <= LV_ROOT;
      va_q    <= '0;
      ent_q   <= '0;
      desc_q  <= '0;
      wb_q    <= '0;
      phys_q  <= '0;
      stat_q  <= '0;
      sup_q   <= 1'b0;
      code_q  <= 1'b0;
      st_q    <= 1'b0;
      prb_q   <= 1'b0;
      dbg_q   <= 1'b0;
      big_q   <= 1'b0;
      wp_q    <= 1'b0;
      fault_q <= 1'b0;
      perm_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          va_q    <= vaddr_i;
          sup_q   <= super_i;
          code_q  <= code_i;
          st_q    <= store_i;
          prb_q   <= probe_i;
          dbg_q   <= debug_i;
          big_q   <= big_page_i;
          ent_q   <= root_entry;
          lvl_q   <= LV_ROOT;
          wp_q    <= 1'b0;
          fault_q <= 1'b0;
          phys_q  <= '0;
          stat_q  <= '0;
          perm_q  <= '0;
          state_q <= ST_RD;
        end
        ST_RD: if (mem_ack_i) begin
          desc_q  <= mem_rdata_i;
          state_q <= ST_CHK;
        end
        ST_CHK: begin
          if (is_upper && !up_valid) begin
            fault_q <= 1'b1;
            state_q <= ST_DONE;
          end else if (lvl_q == LV_PAGE && pg_kind == PG_INVALID) begin
            fault_q <= 1'b1;
            state_q <= ST_DONE;
          end else if (lvl_q == LV_PAGE && pg_kind == PG_INDIRECT) begin
            ent_q   <= ind_entry;
            lvl_q   <= LV_IND;
            state_q <= ST_RD;
          end else begin
            if (desc_wp) begin
              wp_q <= 1'b1;
              if (prb_q && is_upper) stat_q[DSC_WP] <= 1'b1;
            end
            wb_q    <= wb_data;
            state_q <= wb_need ? ST_WB : ST_ADV;
          end
        end
        ST_WB: if (mem_ack_i) state_q <= ST_ADV;
        ST_ADV: begin
          if (is_upper) begin
            if (desc_wp && st_q) begin
              fault_q <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              ent_q   <= next_entry;
              lvl_q   <= ptw_level_e'(lvl_q + 2'd1);
              state_q <= ST_RD;
            end
          end else begin
            phys_q <= page_phys;
            if (prb_q)
              stat_q <= stat_q | (desc_q & STAT_MASK) | page_phys | AW'(1 << STAT_RES);
            if ((wp_q && st_q) || (desc_q[DSC_SUPER] && !sup_q)) begin
              fault_q <= 1'b1;
            end else begin
              perm_q <= {code_q, !wp_q, 1'b1};
            end
            state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign phys_o      = phys_q;
  assign fault_o     = fault_q;
  assign status_o    = stat_q;
  assign perm_r_o    = perm_q[0];
  assign perm_w_o    = perm_q[1];
  assign perm_x_o    = perm_q[2];
  assign mem_req_o   = (state_q == ST_RD) || (state_q == ST_WB);
  assign mem_we_o    = (state_q == ST_WB);
  assign mem_addr_o  = ent_q;
  assign mem_wdata_o = wb_q;

  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                && $stable(mem_wdata_o));
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  assert_debug_no_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && dbg_q |-> !mem_we_o);
  assert_wb_sets_used_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[DSC_USED]);
  assert_store_needs_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && st_q && !fault_o |-> perm_w_o);
  assert_user_super_page_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o && !sup_q |-> !desc_q[DSC_SUPER]);
endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
  localparam logic [31:0] SRP = 32'h0001_0000;
  localparam logic [31:0] URP = 32'h0002_0000;
  localparam logic [31:0] PTB = 32'h0003_0000;
  localparam logic [31:0] PGB = 32'h0004_0000;

  typedef struct packed {
    logic        fault;
    logic [31:0] phys;
    logic [2:0]  perm;
    logic [31:0] stat;
    logic [7:0]  reads;
    logic [7:0]  writes;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic start = 0, sup = 0, code = 0, st = 0, prb = 0, dbg = 0, big = 0;
  logic [31:0] va = 0;
  logic busy, done, pr, pw, px, fault, req, we, ack = 0;
  logic [31:0] phys, stat, addr, wdata, rdata = 0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] ref_mem [logic [31:0]];
  exp_t exp_q[$];
  exp_t last_e;
  int checks = 0, fails = 0, lat = 0, wcnt = 0, nrd = 0, nwr = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ptw_walker dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vaddr_i(va), .super_i(sup),
    .code_i(code), .store_i(st), .probe_i(prb), .debug_i(dbg), .big_page_i(big),
    .root_super_i(SRP), .root_user_i(URP), .busy_o(busy), .done_o(done),
    .phys_o(phys), .perm_r_o(pr), .perm_w_o(pw), .perm_x_o(px), .fault_o(fault),
    .status_o(stat), .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata), .mem_ack_i(ack)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 32'h0;
  endfunction

  task automatic put(input logic [31:0] a, input logic [31:0] v);
    mem[a] = v;
    ref_mem[a] = v;
  endtask

  // memory responder with adjustable latency
  initial begin
    forever begin
      @(negedge clk);
      if (ack) begin
        ack = 0;
        wcnt = 0;
      end else if (req) begin
        if (wcnt >= lat) begin
          ack = 1;
          if (we) begin
            mem[addr] = wdata;
            nwr++;
          end else begin
            rdata = mem.exists(addr) ? mem[addr] : 32'h0;
            nrd++;
          end
        end else wcnt++;
      end
    end
  end

  task automatic ref_walk(input bit wsup, wcode, wst, wprb, wdbg, wbig, input logic [31:0] wva,
                          output exp_t e);
    logic [31:0] r, ent, d, ph;
    bit wp;
    e = '0;
    wp = 0;
    d = 0;
    r = wsup ? SRP : URP;
    for (int lv = 0; lv < 2; lv++) begin
      ent = (lv == 0) ? {r[31:9], wva[31:25], 2'b00} : {d[31:9], wva[24:18], 2'b00};
      d = rd(ent);
      e.reads++;
      if (!d[1]) begin e.fault = 1; return; end
      if (d[2]) begin wp = 1; if (wprb) e.stat[2] = 1'b1; end
      if (!d[3] && !wdbg) begin ref_mem[ent] = d | 32'h8; e.writes++; end
      if (d[2] && wst) begin e.fault = 1; return; end
    end
    ent = wbig ? {d[31:7], wva[17:13], 2'b00} : {d[31:8], wva[17:12], 2'b00};
    d = rd(ent);
    e.reads++;
    if (d[1:0] == 2'b00) begin e.fault = 1; return; end
    if (d[1:0] == 2'b10) begin
      ent = {d[31:2], 2'b00};
      d = rd(ent);
      e.reads++;
    end
    if (d[2]) wp = 1;
    if (!wdbg) begin
      if (wst && !d[2]) begin
        if (!(d[3] && d[4])) begin ref_mem[ent] = d | 32'h18; e.writes++; end
      end else if (!d[3]) begin
        ref_mem[ent] = d | 32'h8; e.writes++;
      end
    end
    ph = wbig ? {d[31:13], 13'b0} : {d[31:12], 12'b0};
    e.phys = ph;
    if (wprb) e.stat = e.stat | (d & 32'h7FC) | ph | 32'h1;
    e.fault = (wp && wst) || (d[7] && !wsup);
    if (!e.fault) e.perm = {wcode, !wp, 1'b1};
  endtask

  // scoreboard monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (done) begin
        if (exp_q.size() == 0) begin
          chk(0, "R10 unexpected done", 1, 0);
        end else begin
          bit img_ok;
          e = exp_q.pop_front();
          chk(fault == e.fault, "R2/R4/R6/R8 fault", {31'b0, fault}, {31'b0, e.fault});
          chk(phys == e.phys, "R5 phys", phys, e.phys);
          chk({px, pw, pr} == e.perm, "R10 perms", {29'b0, px, pw, pr}, {29'b0, e.perm});
          chk(stat == e.stat, "R9 status", stat, e.stat);
          chk(nrd == int'(e.reads), "R2 read count", nrd, {24'b0, e.reads});
          chk(nwr == int'(e.writes), "R3/R7 write count", nwr, {24'b0, e.writes});
          img_ok = 1;
          foreach (ref_mem[k]) if (!mem.exists(k) || mem[k] !== ref_mem[k]) img_ok = 0;
          chk(img_ok, "R3/R7 memory image", {31'b0, img_ok}, 1);
          last_e = e;
        end
      end
    end
  end

  task automatic run(input bit wsup, wcode, wst, wprb, wdbg, wbig, input logic [31:0] wva,
                     input int wlat);
    exp_t e;
    ref_walk(wsup, wcode, wst, wprb, wdbg, wbig, wva, e);
    exp_q.push_back(e);
    @(negedge clk);
    lat = wlat; nrd = 0; nwr = 0;
    sup = wsup; code = wcode; st = wst; prb = wprb; dbg = wdbg; big = wbig; va = wva;
    start = 1;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!done && !busy, "R10 done single pulse", {30'b0, done, busy}, 0);
    chk(phys == e.phys && fault == e.fault, "R10 result held", phys, e.phys);
  endtask

  task automatic chain(input logic [31:0] r, input logic [31:0] v, input bit b,
                       input logic [31:0] rf, input logic [31:0] pf, input logic [31:0] pg);
    put({r[31:9], v[31:25], 2'b00}, PTB | rf);
    put({PTB[31:9], v[24:18], 2'b00}, PGB | pf);
    if (b) put({PGB[31:7], v[17:13], 2'b00}, pg);
    else   put({PGB[31:8], v[17:12], 2'b00}, pg);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL R10 watchdog actual=hang expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !req && !fault && !pr && !pw && !px && stat == 0,
        "R10 reset state", {26'b0, busy, done, req, fault, pr, pw}, 0);

    // R1 R2 R3 R5 R7: supervisor load, all used bits clear
    chain(SRP, 32'h1234_5678, 0, 32'h2, 32'h2, 32'h0ABC_D001);
    run(1, 0, 0, 0, 0, 0, 32'h1234_5678, 0);
    // R1: user root, nothing to write back
    chain(URP, 32'h8642_1000, 0, 32'hA, 32'hA, 32'h0111_1009);
    run(0, 1, 0, 0, 0, 0, 32'h8642_1000, 1);
    // R7: store to unprotected page, modified clear
    chain(SRP, 32'h0040_3000, 0, 32'hA, 32'hA, 32'h0222_2009);
    run(1, 0, 1, 0, 0, 0, 32'h0040_3000, 2);
    // R4: pointer-level protection with a store
    chain(SRP, 32'h0C00_5000, 0, 32'hA, 32'h6, 32'h0333_3001);
    run(1, 0, 1, 0, 0, 0, 32'h0C00_5000, 0);
    // R4 R9: root-level protection, probe load
    chain(SRP, 32'h2000_7000, 0, 32'hE, 32'hA, 32'h0444_4409);
    run(1, 0, 0, 1, 0, 0, 32'h2000_7000, 3);
    // R2: invalid root descriptor
    put({SRP[31:9], 7'h55, 2'b00}, 32'h0);
    run(1, 0, 0, 0, 0, 0, {7'h55, 25'h0}, 1);
    // R6: invalid page descriptor
    chain(URP, 32'h3000_9000, 0, 32'hA, 32'hA, 32'h0555_5000);
    run(0, 0, 0, 0, 0, 0, 32'h3000_9000, 0);
    // R6: indirect page descriptor
    chain(SRP, 32'h4000_B000, 0, 32'hA, 32'hA, 32'h0005_0002);
    put(32'h0005_0000, 32'h0777_7001);
    run(1, 0, 1, 0, 0, 0, 32'h4000_B000, 2);
    // R5: large pages
    chain(SRP, 32'h5003_E000, 1, 32'hA, 32'hA, 32'h0888_9009);
    run(1, 0, 0, 1, 0, 1, 32'h5003_E000, 1);
    // R8: supervisor-only page, user then supervisor
    chain(URP, 32'h6000_D000, 0, 32'hA, 32'hA, 32'h0999_9089);
    run(0, 0, 0, 0, 0, 0, 32'h6000_D000, 0);
    chain(SRP, 32'h6000_D000, 0, 32'hA, 32'hA, 32'h0999_9089);
    run(1, 1, 0, 0, 0, 0, 32'h6000_D000, 0);
    // R7 R3: debug store never writes
    chain(SRP, 32'h7000_F000, 0, 32'h2, 32'h2, 32'h0AAA_A001);
    run(1, 0, 1, 0, 1, 0, 32'h7000_F000, 1);
    // R7 R4: store to protected page: only used bit written, fault
    chain(SRP, 32'h7100_1000, 0, 32'hA, 32'hA, 32'h0BBB_B005);
    run(1, 0, 1, 1, 0, 0, 32'h7100_1000, 2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule